// File: doc/BRIEF.md
# Fixed-Direction GPIO with Edge Interrupts

This peripheral owns eight general-purpose lines whose directions are fixed in hardware. The lower four lines are always driven from an output latch. The upper four are always sampled as inputs. Software reaches the block through a small synchronous byte-wide register port. It sets the output levels, reads the line state, chooses which input edges cause interrupts, and acknowledges the latched events.

Each input line passes through a two-stage synchronizer. A per-input 2-bit field selects detection of rising edges, falling edges, both edges, or none. Detected events collect in a sticky status byte that is cleared by writing ones. The OR of that byte drives one shared interrupt line.

The register port carries no streaming data, so it has no valid/ready handshake. A write is taken on every clock edge where the write strobe is high. Reads are combinational from the current address, and a read has no side effect.

Top module: `gpio_fixdir_irq`

## Requirements
- R1: After reset, `pin_out` is 0, `irq` is 0, and the data, configuration and status registers read 0x00 while all input pins are low.
- R2: Offset 0 always reads 0x0F, meaning lines 0 to 3 are outputs and lines 4 to 7 are inputs. Writes to offset 0 change nothing.
- R3: A write to offset 1 drives `pin_out` with write bits 3:0 from the next clock edge onward. Write bits 7:4 are ignored. `pin_out` changes only on such a write.
- R4: A read of offset 1 returns the output latch in bits 3:0 and the synchronized input levels in bits 7:4. A pin change becomes visible there after the second clock edge that follows it.
- R5: Offset 3 is the edge configuration and reads back as written. Input k (pin_in[k], line 4+k) uses bits 2k and 2k+1. Bit 2k enables falling-edge detection and bit 2k+1 enables rising-edge detection.
- R6: With only the rising bit set, a 0-to-1 change on the input sets its status bit and a 1-to-0 change does not.
- R7: With only the falling bit set, a 1-to-0 change sets the status bit and a 0-to-1 change does not.
- R8: With both bits set, either change sets the status bit.
- R9: A field of 00 masks its input, so that input sets no status bit. Writing 0x00 to offset 3 masks every input.
- R10: Offset 4 is the status register. Bit k reports an event on input k, and bits 7:4 read 0. An event is visible after the third clock edge that follows the pin change.
- R11: A status bit stays set until a 1 is written to it at offset 4. Writing 0 leaves it as it is. An event that lands in the same cycle as the clearing write keeps the bit set.
- R12: `irq` is high exactly while any status bit is set, and it stays high until every status bit is cleared.
- R13: Offsets 2, 5, 6 and 7 read 0x00, and writes to them change no register and no pin.
- R14: Writes to the output lines never set a status bit or raise `irq`, even when every edge is enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; all state updates on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Write strobe; the write is taken on the clock edge where it is high |
| reg_addr | input | 3 | Register offset for both read and write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| pin_in | input | 4 | Input lines 4 to 7; asynchronous to `clk` |
| pin_out | output | 4 | Output lines 0 to 3 |
| irq | output | 1 | Combined interrupt, the OR of the status bits |

## Verification
A software acknowledge (a write-one-to-clear at offset 4) and a freshly detected edge on the same input can update that status bit at the same clock edge. The bench provokes this by leaving a status bit set, changing that input's pin, and then timing the clearing write so that it commits at exactly the third edge after the pin change, which is the edge where the new event is latched. The bench judges the result by reading the status register afterwards: the bit must still be set and `irq` must still be high. A second clearing write must then bring both to 0.

// File: rtl/gpio_fd_pkg.sv
package gpio_fd_pkg;
  // Register offsets. Software depends on these values.
  localparam int OFF_DIR  = 0;
  localparam int OFF_DATA = 1;
  localparam int OFF_CFG  = 3;
  localparam int OFF_STAT = 4;

  // Default geometry of the block.
  localparam int DEF_N_OUT  = 4;
  localparam int DEF_N_IN   = 4;
  localparam int DEF_ADDR_W = 3;
  localparam int DEF_REG_W  = 8;

  // Bit positions inside one 2-bit edge field.
  localparam int FLD_FALL = 0;
  localparam int FLD_RISE = 1;
endpackage

// File: rtl/gpio_fd_sync.sv
module gpio_fd_sync #(
  parameter int WIDTH  = 4,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  logic [WIDTH-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int s = 0; s < STAGES; s++) chain[s] <= '0;
    end else begin
      chain[0] <= async_i;
      for (int s = 1; s < STAGES; s++) chain[s] <= chain[s-1];
    end
  end

  assign sync_o = chain[STAGES-1];
endmodule

// File: rtl/gpio_fd_edge.sv
module gpio_fd_edge
  import gpio_fd_pkg::*;
#(
  parameter int N_IN = 4,
  localparam int CFG_W = 2 * N_IN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_IN-1:0]  lvl_i,
  input  logic [CFG_W-1:0] cfg_i,
  input  logic [N_IN-1:0]  clr_i,
  output logic [N_IN-1:0]  stat_o,
  output logic             irq_o
);
  logic [N_IN-1:0] prev_q;
  logic [N_IN-1:0] stat_q;
  logic [N_IN-1:0] hit;

  // One qualifier per input line.
  for (genvar k = 0; k < N_IN; k++) begin : g_det
    logic rise, fall;
    assign rise   = lvl_i[k] & ~prev_q[k];
    assign fall   = ~lvl_i[k] & prev_q[k];
    assign hit[k] = (rise & cfg_i[2*k+FLD_RISE]) | (fall & cfg_i[2*k+FLD_FALL]);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= '0;
      stat_q <= '0;
    end else begin
      prev_q <= lvl_i;
      // A new event wins over a clear of the same bit.
      stat_q <= (stat_q & ~clr_i) | hit;
    end
  end

  assign stat_o = stat_q;
  assign irq_o  = |stat_q;

  // R11: a set bit that was not cleared stays set.
  assert_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((($past(stat_q) & ~$past(clr_i)) & ~stat_q) == '0));

  // R11: a cleared bit with no concurrent event reads 0 afterwards.
  assert_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_i & ~hit)) == '0));

  // R9: an all-masked configuration sets no new status bit.
  assert_mask_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_i == '0) |=> ((stat_q & ~$past(stat_q)) == '0));

  // R12: irq rises only after a qualified edge.
  assert_irq_cause_R12: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq_o) |-> $past(hit != '0));
endmodule

// File: rtl/gpio_fixdir_irq.sv
module gpio_fixdir_irq
  import gpio_fd_pkg::*;
#(
  parameter int N_OUT  = DEF_N_OUT,
  parameter int N_IN   = DEF_N_IN,
  parameter int ADDR_W = DEF_ADDR_W,
  parameter int REG_W  = DEF_REG_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  output logic [REG_W-1:0]  reg_rdata,
  input  logic [N_IN-1:0]   pin_in,
  output logic [N_OUT-1:0]  pin_out,
  output logic              irq
);
  localparam int CFG_W = 2 * N_IN;
  localparam logic [ADDR_W-1:0] A_DIR  = ADDR_W'(OFF_DIR);
  localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFF_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFF_STAT);
  localparam logic [REG_W-1:0]  DIR_PATTERN = REG_W'({N_OUT{1'b1}});

  logic [N_OUT-1:0] out_q;
  logic [CFG_W-1:0] cfg_q;
  logic [N_IN-1:0]  in_sync;
  logic [N_IN-1:0]  stat;
  logic [N_IN-1:0]  clr;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_q <= '0;
      cfg_q <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_DATA) out_q <= reg_wdata[N_OUT-1:0];
      if (reg_addr == A_CFG)  cfg_q <= reg_wdata[CFG_W-1:0];
    end
  end

  assign clr = (reg_we && reg_addr == A_STAT) ? reg_wdata[N_IN-1:0] : '0;

  gpio_fd_sync #(.WIDTH(N_IN), .STAGES(2)) u_sync (
    .clk     (clk),
    .rst_n   (rst_n),
    .async_i (pin_in),
    .sync_o  (in_sync)
  );

  gpio_fd_edge #(.N_IN(N_IN)) u_edge (
    .clk    (clk),
    .rst_n  (rst_n),
    .lvl_i  (in_sync),
    .cfg_i  (cfg_q),
    .clr_i  (clr),
    .stat_o (stat),
    .irq_o  (irq)
  );

  always_comb begin
    unique case (reg_addr)
      A_DIR:   reg_rdata = DIR_PATTERN;
      A_DATA:  reg_rdata = REG_W'({in_sync, out_q});
      A_CFG:   reg_rdata = REG_W'(cfg_q);
      A_STAT:  reg_rdata = REG_W'(stat);
      default: reg_rdata = '0;
    endcase
  end

  assign pin_out = out_q;

  // R3: output lines move only after a data write.
  assert_out_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_DATA) |=> $stable(pin_out));

  // R5: the configuration changes only through its own offset.
  assert_cfg_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_we && reg_addr == A_CFG) |=> $stable(cfg_q));
endmodule

// File: tb/tb_gpio_fixdir_irq.sv
module tb_gpio_fixdir_irq;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic [3:0] pin_in = '0;
  logic [3:0] pin_out;
  logic       irq;

  int n_vec = 0;
  int n_bad = 0;
  bit done = 1'b0;

  typedef struct {
    int         kind;  // 0 rdata, 1 pin_out, 2 irq
    logic [7:0] exp;
    string      tag;
  } item_t;
  item_t sb[$];

  always #2 clk = ~clk;  // 250 MHz

  gpio_fixdir_irq dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pin_in(pin_in),
    .pin_out(pin_out), .irq(irq)
  );

  // Monitor: compare on the falling edge, away from the active edge.
  always @(negedge clk) begin
    item_t it;
    logic [7:0] got;
    while (sb.size() > 0) begin
      it = sb.pop_front();
      case (it.kind)
        0:       got = reg_rdata;
        1:       got = {4'h0, pin_out};
        default: got = {7'h0, irq};
      endcase
      n_vec++;
      if (got !== it.exp) begin
        n_bad++;
        $display("FAIL %s kind=%0d actual=0x%02h expected=0x%02h", it.tag, it.kind, got, it.exp);
      end
    end
  end

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic wait_n(input int n);
    for (int i = 0; i < n; i++) tick();
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    tick();
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, input logic [7:0] e, input string tag);
    reg_addr = a;
    sb.push_back('{0, e, tag});
    tick();
  endtask

  task automatic chk_pin(input logic [3:0] e, input string tag);
    sb.push_back('{1, {4'h0, e}, tag});
    tick();
  endtask

  task automatic chk_irq(input logic e, input string tag);
    sb.push_back('{2, {7'h0, e}, tag});
    tick();
  endtask

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    wait_n(3);
    rst_n = 1'b1;
    tick();

    // R1 reset state
    rd(3'd1, 8'h00, "R1 data");
    rd(3'd3, 8'h00, "R1 cfg");
    rd(3'd4, 8'h00, "R1 status");
    chk_pin(4'h0, "R1 pin_out");
    chk_irq(1'b0, "R1 irq");

    // R2 direction register is fixed
    rd(3'd0, 8'h0F, "R2 dir");
    wr(3'd0, 8'hF0);
    rd(3'd0, 8'h0F, "R2 dir after write");

    // R3 output writes, upper bits ignored
    wr(3'd1, 8'hA5);
    chk_pin(4'h5, "R3 pin_out");
    rd(3'd1, 8'h05, "R3 data readback");
    wr(3'd1, 8'hFF);
    rd(3'd1, 8'h0F, "R3 upper ignored");

    // R4 input sampling latency; cfg is 0 so R9 masks
    pin_in = 4'h6;
    tick();
    rd(3'd1, 8'h0F, "R4 not yet");
    rd(3'd1, 8'h6F, "R4 synchronized");
    wait_n(2);
    rd(3'd4, 8'h00, "R9 masked at reset cfg");
    pin_in = 4'h0;
    wait_n(4);
    rd(3'd4, 8'h00, "R9 masked fall");

    // R5 field layout: f3=both f2=rise f1=fall f0=off
    wr(3'd3, 8'hE4);
    rd(3'd3, 8'hE4, "R5 cfg readback");

    // R6/R8 rising edges on all inputs
    pin_in = 4'hF;
    wait_n(3);
    rd(3'd4, 8'h0C, "R6 R8 rise status");
    chk_irq(1'b1, "R12 irq set");
    wr(3'd4, 8'h0C);
    rd(3'd4, 8'h00, "R11 cleared");
    chk_irq(1'b0, "R12 irq cleared");

    // R7/R8 falling edges
    pin_in = 4'h0;
    wait_n(3);
    rd(3'd4, 8'h0A, "R7 R8 fall status");

    // R12 partial clear, R11 zero write
    wr(3'd4, 8'h02);
    rd(3'd4, 8'h08, "R11 partial clear");
    chk_irq(1'b1, "R12 irq held");
    wr(3'd4, 8'h00);
    rd(3'd4, 8'h08, "R11 zero write keeps");
    wr(3'd4, 8'hF8);
    rd(3'd4, 8'h00, "R10 upper write bits");
    chk_irq(1'b0, "R12 irq low");

    // R10 status latency
    pin_in = 4'h8;
    tick(); tick();
    rd(3'd4, 8'h00, "R10 not yet");
    rd(3'd4, 8'h08, "R10 latched");

    // R11 clear and new event in the same cycle
    pin_in = 4'h0;
    tick(); tick();
    wr(3'd4, 8'h08);
    rd(3'd4, 8'h08, "R11 event beats clear");
    chk_irq(1'b1, "R11 irq kept");
    wr(3'd4, 8'h08);
    rd(3'd4, 8'h00, "R11 final clear");

    // R13 unused offsets
    wr(3'd2, 8'hFF);
    wr(3'd5, 8'hFF);
    wr(3'd7, 8'h00);
    rd(3'd2, 8'h00, "R13 off2");
    rd(3'd5, 8'h00, "R13 off5");
    rd(3'd6, 8'h00, "R13 off6");
    rd(3'd7, 8'h00, "R13 off7");
    rd(3'd3, 8'hE4, "R13 cfg intact");
    chk_pin(4'hF, "R13 pins intact");

    // R14 output toggles never interrupt
    wr(3'd3, 8'hFF);
    wr(3'd1, 8'h00);
    wr(3'd1, 8'h0F);
    wr(3'd1, 8'h00);
    wait_n(3);
    rd(3'd4, 8'h00, "R14 no status");
    chk_irq(1'b0, "R14 no irq");

    // R9 global mask
    wr(3'd3, 8'h00);
    pin_in = 4'hF;
    wait_n(4);
    rd(3'd4, 8'h00, "R9 all masked rise");
    pin_in = 4'h0;
    wait_n(4);
    rd(3'd4, 8'h00, "R9 all masked fall");
    chk_irq(1'b0, "R9 irq low");

    tick();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule